// File: doc/BRIEF.md
# Message-Based Interrupt Controller

This block gathers up to 32 peripheral interrupt lines and reports them to a processor as memory writes instead of a wire. A rising edge on a source line is remembered in a pending register. If that source is enabled in the mask, its bit is also recorded in a request register, and the controller queues an outgoing write. The address and data of that write both come from a single target register. The address is the target with its five low bits cleared, and the data is those five low bits.

Software programs the block through a small register bus. The bus has a write strobe, a read strobe, a byte offset and 32-bit data, and read data is returned in the same cycle. The pending register empties on any access to its offset. One control bit holds back message delivery while the registers continue to track events. Outgoing messages wait in a four-entry queue behind a valid/ready port. A message that finds the queue full is lost and raises a sticky overflow flag.

The fixed source assignments are: serial port 5, parallel port 7, network 8, disk interface 9, audio 13, the controller itself 14, and keyboard/mouse 26.

Top module: `msg_irq_ctrl`

## Requirements
- R1: After reset, the request, mask, pending and control registers read zero, the target register reads the TGT_RESET parameter, msg_valid is low and msg_ovf is low.
- R2: Register byte offsets are 0x00 request, 0x04 mask, 0x08 pending, 0x0C control and 0x10 target. Data written to mask or target reads back at the same offset. Any other offset reads zero, and writes to it are ignored.
- R3: The mask keeps only bits 5, 7, 8, 9, 13, 14, 16 to 21 and 26 (0x043F63A0). All other written bits read back as zero.
- R4: The control register stores only bit 8 (suppress) and reads back only that bit.
- R5: A rising edge on src_i[n] sets pending bit n one clock later. A line held high produces no further event.
- R6: A rising edge on an unmasked source sets the matching request bit. Request bits stay set until reset, and writes to offset 0x00 change nothing.
- R7: Each clock cycle with at least one unmasked rising edge, and with suppress clear, queues exactly one message. Its address is target & 0xFFFFFFE0 and its data is target & 0x1F, both taken from the target at that cycle. Masked edges queue nothing.
- R8: While suppress is set, no message is queued, but pending and request bits are still updated.
- R9: A read of offset 0x08 returns the pending value and then clears it. A write to 0x08 clears it whatever the data. A rising edge in the same cycle as the clear stays pending.
- R10: Messages leave in queue order on msg_valid/msg_ready, and address and data stay stable while msg_valid is high and msg_ready is low. Up to QDEPTH (4) messages wait in the queue.
- R11: A message that arrives while the queue holds QDEPTH entries is dropped, and msg_ovf goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt source lines, edge detected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle |
| msg_valid | output | 1 | Interrupt message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data word |
| msg_ovf | output | 1 | Sticky queue overflow flag |

## Verification
The assertions assume that reg_rd and reg_wr are never both high in the same cycle. They also assume that a source line needs a full cycle low between edges to count as two events, and that msg_ready is sampled only at the rising edge. The bench drives every input on the falling edge and raises only one strobe per access. It lowers each source line for a whole cycle before raising it again. To reach the corner cases it holds msg_ready low for a controlled number of cycles, which fills the queue, and it issues a pending clear in the same cycle as a new edge.

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl #(
  parameter logic [31:0] TGT_RESET  = 32'h0000_0003,
  parameter logic [31:0] LEGAL_MASK = 32'h043F_63A0,
  parameter int          QDEPTH     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_i,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [31:0] msg_addr,
  output logic [31:0] msg_data,
  output logic        msg_ovf
);

  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam logic [PW:0]   FULL  = (PW+1)'(QDEPTH);
  localparam logic [PW-1:0] LAST  = PW'(QDEPTH - 1);
  localparam logic [4:0] A_REQ  = 5'h00;
  localparam logic [4:0] A_MASK = 5'h04;
  localparam logic [4:0] A_PEND = 5'h08;
  localparam logic [4:0] A_CTRL = 5'h0C;
  localparam logic [4:0] A_TGT  = 5'h10;

  logic [31:0] src_q, req, mask, pend, tgt;
  logic        sup;
  logic [31:0] tq [QDEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  logic [31:0] rise;
  logic        fire, full, push, pop, pend_clr;
  logic [31:0] head;

  assign rise     = src_i & ~src_q;
  assign fire     = (|(rise & mask)) && !sup;
  assign full     = (cnt == FULL);
  assign push     = fire && !full;
  assign pop      = msg_valid && msg_ready;
  assign pend_clr = (reg_rd || reg_wr) && (reg_addr == A_PEND);

  assign head      = tq[rp];
  assign msg_valid = (cnt != '0);
  assign msg_addr  = {head[31:5], 5'b0};
  assign msg_data  = {27'b0, head[4:0]};

  always_comb begin
    case (reg_addr)
      A_REQ:   reg_rdata = req;
      A_MASK:  reg_rdata = mask;
      A_PEND:  reg_rdata = pend;
      A_CTRL:  reg_rdata = {23'b0, sup, 8'b0};
      A_TGT:   reg_rdata = tgt;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      req     <= '0;
      mask    <= '0;
      pend    <= '0;
      tgt     <= TGT_RESET;
      sup     <= 1'b0;
      msg_ovf <= 1'b0;
    end else begin
      src_q <= src_i;
      req   <= req | (rise & mask);
      pend  <= (pend_clr ? '0 : pend) | rise;
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata & LEGAL_MASK;
      if (reg_wr && reg_addr == A_CTRL) sup  <= reg_wdata[8];
      if (reg_wr && reg_addr == A_TGT)  tgt  <= reg_wdata;
      if (fire && full) msg_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) tq[wp] <= tgt;
  end

  assert_mask_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_MASK) |-> ((reg_rdata & ~LEGAL_MASK) == '0));

  assert_req_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req & $past(req)) == $past(req)));

  assert_no_msg_suppressed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sup && cnt == '0) |=> !msg_valid);

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_PEND && src_i == '0) |=> (pend == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ovf |=> msg_ovf);

endmodule

// File: tb/msg_irq_ctrl_bench.sv
`timescale 1ns/1ps
module msg_irq_ctrl_bench;
  localparam logic [31:0] TGT = 32'h0000_1A03;
  localparam int NV = 18;
  // {req id[73:70], write[69], addr[68:64], wdata[63:32], expected[31:0]}
  localparam logic [73:0] VEC [NV] = '{
    {4'd1, 1'b0, 5'h00, 32'h0, 32'h0},             // R1 request
    {4'd1, 1'b0, 5'h04, 32'h0, 32'h0},             // R1 mask
    {4'd1, 1'b0, 5'h08, 32'h0, 32'h0},             // R1 pending
    {4'd1, 1'b0, 5'h0C, 32'h0, 32'h0},             // R1 control
    {4'd1, 1'b0, 5'h10, 32'h0, TGT},               // R1 target
    {4'd3, 1'b1, 5'h04, 32'hFFFF_FFFF, 32'h0},     // R3
    {4'd3, 1'b0, 5'h04, 32'h0, 32'h043F_63A0},     // R3
    {4'd4, 1'b1, 5'h0C, 32'hFFFF_FFFF, 32'h0},     // R4
    {4'd4, 1'b0, 5'h0C, 32'h0, 32'h0000_0100},     // R4
    {4'd4, 1'b1, 5'h0C, 32'h0, 32'h0},             // R4
    {4'd4, 1'b0, 5'h0C, 32'h0, 32'h0},             // R4
    {4'd2, 1'b1, 5'h10, 32'h1234_5678, 32'h0},     // R2
    {4'd2, 1'b0, 5'h10, 32'h0, 32'h1234_5678},     // R2
    {4'd6, 1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0},     // R6
    {4'd6, 1'b0, 5'h00, 32'h0, 32'h0},             // R6
    {4'd2, 1'b1, 5'h14, 32'hFFFF_FFFF, 32'h0},     // R2
    {4'd2, 1'b0, 5'h14, 32'h0, 32'h0},             // R2
    {4'd2, 1'b1, 5'h04, 32'h0, 32'h0}              // R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic msg_valid, msg_ready = 1'b0, msg_ovf;
  logic [31:0] msg_addr, msg_data;

  int checks = 0, errors = 0, hs = 0;
  logic [31:0] log_a [16];
  logic [31:0] log_d [16];

  always #2 clk = ~clk;

  msg_irq_ctrl #(.TGT_RESET(TGT), .LEGAL_MASK(32'h043F_63A0), .QDEPTH(4)) u_msg_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_ovf(msg_ovf));

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (hs < 16) begin
        log_a[hs] = msg_addr;
        log_d[hs] = msg_data;
      end
      hs = hs + 1;
    end
  end

  task automatic check(input int rid, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", rid, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic set_src(input int idx, input logic v);
    @(negedge clk);
    src_i[idx] = v;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int base;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    check(1, {31'b0, msg_valid}, 32'd0, "msg_valid after reset");
    check(1, {31'b0, msg_ovf}, 32'd0, "msg_ovf after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) reg_write(VEC[i][68:64], VEC[i][63:32]);
      else begin
        reg_read(VEC[i][68:64], rv);
        check(int'(VEC[i][73:70]), rv, VEC[i][31:0], "register table");
      end
    end

    // R5 R7 R10: unmasked edge, stall then drain
    reg_write(5'h04, 32'h20);
    set_src(5, 1'b1);
    check(7, {31'b0, msg_valid}, 32'd1, "message queued");
    check(7, msg_addr, 32'h1234_5660, "message address");
    check(7, msg_data, 32'h0000_0018, "message data");
    idle(3);
    check(10, msg_addr, 32'h1234_5660, "address held while stalled");
    reg_read(5'h08, rv); check(5, rv, 32'h20, "pending after edge");
    reg_read(5'h08, rv); check(9, rv, 32'h0, "pending cleared by read");
    reg_read(5'h00, rv); check(6, rv, 32'h20, "request after edge");
    base = hs;
    @(negedge clk) msg_ready = 1'b1;
    idle(4);
    check(5, hs - base, 32'd1, "one message for held line");
    check(10, {31'b0, msg_valid}, 32'd0, "queue empty after drain");

    // R7 R5: masked source
    set_src(7, 1'b1);
    idle(2);
    check(7, {31'b0, msg_valid}, 32'd0, "masked edge no message");
    reg_read(5'h00, rv); check(6, rv, 32'h20, "masked edge no request");
    reg_read(5'h08, rv); check(5, rv, 32'h80, "masked edge pending");
    set_src(7, 1'b0);
    set_src(7, 1'b1);
    reg_write(5'h08, 32'h0);
    reg_read(5'h08, rv); check(9, rv, 32'h0, "pending cleared by write");

    // R9: clear and new edge in the same cycle
    set_src(7, 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h08; reg_wdata = 32'hFFFF_FFFF; src_i[7] = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
    reg_read(5'h08, rv); check(9, rv, 32'h80, "edge survives same-cycle clear");

    // R8: suppression
    reg_write(5'h04, 32'h120);
    reg_write(5'h0C, 32'h100);
    base = hs;
    set_src(8, 1'b1);
    idle(3);
    check(8, hs - base, 32'd0, "no message while suppressed");
    reg_read(5'h00, rv); check(8, rv, 32'h120, "request updated while suppressed");
    reg_read(5'h08, rv); check(8, rv, 32'h100, "pending updated while suppressed");
    reg_write(5'h0C, 32'h0);

    // R11 R10: fill queue, overflow, drain in order
    @(negedge clk) msg_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      reg_write(5'h10, 32'hA000_0000 | (k << 8) | k);
      set_src(5, 1'b0);
      set_src(5, 1'b1);
      if (k == 3) check(11, {31'b0, msg_ovf}, 32'd0, "no overflow at depth");
    end
    check(11, {31'b0, msg_ovf}, 32'd1, "overflow on fifth message");
    base = hs;
    @(negedge clk) msg_ready = 1'b1;
    idle(8);
    check(11, hs - base, 32'd4, "fifth message dropped");
    check(10, log_a[base], 32'hA000_0000, "first message address");
    check(10, log_d[base], 32'h0, "first message data");
    check(10, log_a[base+3], 32'hA000_0300, "fourth message address");
    check(10, log_d[base+3], 32'h3, "fourth message data");
    check(11, {31'b0, msg_ovf}, 32'd1, "overflow sticky");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule